// File: doc/BRIEF.md
# Four-Channel PWM Enable Stage with Pin Override

This block sits between a prescaler, a small pulse-width modulator and a general-purpose port of four pins. A register interface holds a four-bit channel enable register, a port data register, a pin direction register, and an 8-bit period and duty register per channel. Each channel gets a one-cycle strobe (`src_tick`) from an external prescaler. That strobe marks the start of each cycle of the channel's clock source.

The enable bit of a channel takes over its pin at once. The pin becomes an output and carries the PWM waveform. The stored direction bit is never changed. The counter only starts or stops on a `src_tick`, so a channel never begins or ends partway through a source cycle. When the bit is cleared, the pin again follows its direction and port data bits.

The bus has no back-pressure. `bus_ready` is always high, so every request is taken in the cycle `bus_valid` is high. Read data returns one cycle later with `rd_valid`. Neither side can stall the other.

Top module: `pwm_enable_stage`

## Requirements
- R1: After reset, all registers read zero, every `pin_oe` bit is 0 and every `pin_out` bit is 0.
- R2: The enable register is at address 0x0. Bit k enables channel k, which drives pin k. Bits 7:4 read as zero and ignore writes. The register can be written at any time.
- R3: From the cycle after an enable bit is written to 1, `pin_oe` of that pin is 1, whatever its direction bit is.
- R4: The direction register (address 0x2) and the port data register (address 0x1) are never changed by the enables. From the cycle after an enable bit is cleared, `pin_oe` equals the direction bit and `pin_out` equals the port data bit.
- R5: While a channel is enabled, `pin_out` carries its PWM output. That output stays 0 until the first `src_tick` of the channel after the enable. Counting starts at 0 on that tick.
- R6: A running counter advances by one on each `src_tick` and returns to 0 on the tick after it reaches the period value P. The period is therefore P+1 ticks. The output is 1 while the count is below the duty value D, so D greater than P gives a constant 1.
- R7: Stop and restart happen only on a `src_tick`. If the bit is cleared and set again with no tick in between, the waveform continues from its current count. If a tick falls while the bit is clear, the counter returns to 0.
- R8: `bus_ready` is always 1. A read returns its data on `rd_data`, with `rd_valid` high, in the cycle after it is accepted. Channel k has its period at address 4+2k and its duty at address 5+2k.
- R9: A read of an unmapped address returns zero, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register request present |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| src_tick | input | 4 | Per-channel clock-source cycle start strobe |
| pin_out | output | 4 | Pin output value |
| pin_oe | output | 4 | Pin output enable |

## Verification
The assertions take `src_tick` as a single-cycle strobe per channel. They also assume that a read is never accepted in the same cycle as a write to the same register. The stimulus raises each tick for exactly one cycle. It never overlaps a tick with a bus request for the same channel, and it issues each bus request alone, so every expected pin value can be tied to one known count.

// File: rtl/pwmen_pkg.sv
package pwmen_pkg;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int AW  = 4;
  localparam int DW  = 8;

  localparam int ADDR_ENABLE = 0;
  localparam int ADDR_PORT   = 1;
  localparam int ADDR_DIR    = 2;
  localparam int ADDR_CHBASE = 4;

  typedef logic [NCH-1:0][CW-1:0] ch_word_t;
endpackage

// File: rtl/pwmen_regs.sv
module pwmen_regs
  import pwmen_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data,
  output logic [NCH-1:0]      en_q,
  output logic [NCH-1:0]      port_q,
  output logic [NCH-1:0]      dir_q,
  output ch_word_t            period_q,
  output ch_word_t            duty_q
);
  localparam int PAD = DW - NCH;

  logic          wr_fire, rd_fire;
  logic [DW-1:0] rd_mux;

  assign wr_fire = bus_valid &&  bus_write;
  assign rd_fire = bus_valid && !bus_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      port_q   <= '0;
      dir_q    <= '0;
      period_q <= '0;
      duty_q   <= '0;
    end else if (wr_fire) begin
      if (bus_addr == AW'(ADDR_ENABLE)) en_q   <= bus_wdata[NCH-1:0];
      if (bus_addr == AW'(ADDR_PORT))   port_q <= bus_wdata[NCH-1:0];
      if (bus_addr == AW'(ADDR_DIR))    dir_q  <= bus_wdata[NCH-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (bus_addr == AW'(ADDR_CHBASE + 2*c))     period_q[c] <= bus_wdata[CW-1:0];
        if (bus_addr == AW'(ADDR_CHBASE + 2*c + 1)) duty_q[c]   <= bus_wdata[CW-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(ADDR_ENABLE)) rd_mux = {{PAD{1'b0}}, en_q};
    if (bus_addr == AW'(ADDR_PORT))   rd_mux = {{PAD{1'b0}}, port_q};
    if (bus_addr == AW'(ADDR_DIR))    rd_mux = {{PAD{1'b0}}, dir_q};
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == AW'(ADDR_CHBASE + 2*c))     rd_mux = DW'(period_q[c]);
      if (bus_addr == AW'(ADDR_CHBASE + 2*c + 1)) rd_mux = DW'(duty_q[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      rd_data  <= rd_fire ? rd_mux : '0;
    end
  end

  // R4: only a write to the direction address may change the direction register
  assert_dir_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && bus_addr == AW'(ADDR_DIR)) |=> $stable(dir_q));

  // R2: the upper bits of a read of the enable register are zero
  assert_enable_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && bus_addr == AW'(ADDR_ENABLE) |=> rd_data[DW-1:NCH] == '0);

  // R8: read data is valid exactly one cycle after a read is accepted
  assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_valid);
endmodule

// File: rtl/pwmen_chan.sv
module pwmen_chan
  import pwmen_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] duty,
  output logic          pwm
);
  logic          run_q;
  logic [CW-1:0] cnt_q;

  // The enable bit is sampled only at the start of a source cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (tick) begin
      run_q <= en;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (!run_q || !en)        cnt_q <= '0;
      else if (cnt_q >= period) cnt_q <= '0;
      else                      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign pwm = run_q && (cnt_q < duty);

  // R7: the run state only changes on a source tick
  assert_run_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(run_q));

  // R5: a channel that is not running produces no pulse and holds its count at zero
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!pwm && cnt_q == '0));

  // R6: a tick at or past the period wraps the counter
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_q && en && cnt_q >= period) |=> cnt_q == '0);
endmodule

// File: rtl/pwmen_pinmux.sv
module pwmen_pinmux
  import pwmen_pkg::*;
(
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] dir,
  input  logic [NCH-1:0] port,
  input  logic [NCH-1:0] pwm,
  output logic [NCH-1:0] pin_out,
  output logic [NCH-1:0] pin_oe
);
  for (genvar k = 0; k < NCH; k++) begin : g_pin
    assign pin_oe[k]  = en[k] | dir[k];
    assign pin_out[k] = en[k] ? pwm[k] : port[k];
  end
endmodule

// File: rtl/pwm_enable_stage.sv
module pwm_enable_stage
  import pwmen_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_valid,
  output logic           bus_ready,
  input  logic           bus_write,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  input  logic [NCH-1:0] src_tick,
  output logic [NCH-1:0] pin_out,
  output logic [NCH-1:0] pin_oe
);
  logic [NCH-1:0] en_q, port_q, dir_q, pwm;
  ch_word_t       period_q, duty_q;

  assign bus_ready = 1'b1;

  pwmen_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .en_q     (en_q),
    .port_q   (port_q),
    .dir_q    (dir_q),
    .period_q (period_q),
    .duty_q   (duty_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwmen_chan u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (src_tick[c]),
      .en    (en_q[c]),
      .period(period_q[c]),
      .duty  (duty_q[c]),
      .pwm   (pwm[c])
    );
  end

  pwmen_pinmux u_mux (
    .en     (en_q),
    .dir    (dir_q),
    .port   (port_q),
    .pwm    (pwm),
    .pin_out(pin_out),
    .pin_oe (pin_oe)
  );
endmodule

// File: tb/test_pwm_enable_stage.sv
module test_pwm_enable_stage;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_ready, rd_valid;
  logic [7:0] rd_data;
  logic [3:0] src_tick = '0;
  logic [3:0] pin_out, pin_oe;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_enable_stage i_pwm_enable_stage (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .src_tick(src_tick), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 4'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = 4'(a);
    @(negedge clk);
    bus_valid = 0;
    chk("R8 rd_valid", int'(rd_valid), 1);
    d = int'(rd_data);
  endtask

  task automatic tick(input int c);
    @(negedge clk);
    src_tick[c] = 1'b1;
    @(negedge clk);
    src_tick = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_oe", int'(pin_oe), 0);
    chk("R1 pin_out", int'(pin_out), 0);
    chk("R8 bus_ready", int'(bus_ready), 1);
    for (int a = 0; a < 12; a++) begin
      rd(a, v); chk("R1 reg zero", v, 0);
    end
    // R2 upper bits ignored
    wr(0, 8'hFF); rd(0, v); chk("R2 enable readback", v, 8'h0F);
    wr(0, 0);     rd(0, v); chk("R2 enable cleared", v, 0);
    // R9 unmapped
    for (int a = 12; a < 16; a++) begin
      wr(a, 8'hFF); rd(a, v); chk("R9 unmapped read", v, 0);
    end
    wr(3, 8'h77); rd(3, v); chk("R9 gap address", v, 0);
    rd(0, v); chk("R9 enable unchanged", v, 0);
    rd(4, v); chk("R9 period unchanged", v, 0);
    // port pattern: data 1010, direction 0101
    wr(1, 8'h0A); wr(2, 8'h05);
    chk("R4 pins follow port", int'(pin_out), 8'h0A);
    chk("R4 oe follows dir", int'(pin_oe), 8'h05);

    // R6 sweep over period/duty
    for (int p = 0; p < 6; p++) begin
      for (int d = 0; d < 8; d++) begin
        int c = (p + d) % 4;
        wr(4 + 2*c, p); wr(5 + 2*c, d);
        wr(0, 1 << c);
        chk("R3 oe forced", int'(pin_oe[c]), 1);
        chk("R5 low before tick", int'(pin_out[c]), 0);
        for (int j = 0; j <= 2*(p+1); j++) begin
          tick(c);
          chk("R6 waveform", int'(pin_out[c]), ((j % (p+1)) < d) ? 1 : 0);
        end
        wr(0, 0);
        chk("R4 out back to port", int'(pin_out[c]), (8'h0A >> c) & 1);
        chk("R4 oe back to dir", int'(pin_oe[c]), (8'h05 >> c) & 1);
        tick(c);
      end
    end
    rd(2, v); chk("R4 dir unchanged", v, 8'h05);
    rd(1, v); chk("R4 port unchanged", v, 8'h0A);

    // R7 toggle without tick keeps counting
    wr(6, 3); wr(7, 2); wr(0, 2);
    tick(1); chk("R7 count0", int'(pin_out[1]), 1);
    tick(1); chk("R7 count1", int'(pin_out[1]), 1);
    wr(0, 0); wr(0, 2);
    tick(1); chk("R7 continued count2", int'(pin_out[1]), 0);
    tick(1); chk("R7 continued count3", int'(pin_out[1]), 0);
    tick(1); chk("R7 continued wrap", int'(pin_out[1]), 1);
    // R7 toggle with tick restarts
    tick(1); chk("R7 count1 again", int'(pin_out[1]), 1);
    tick(1); chk("R7 count2 again", int'(pin_out[1]), 0);
    wr(0, 0); tick(1); wr(0, 2);
    chk("R5 stopped until tick", int'(pin_out[1]), 0);
    tick(1); chk("R7 restart at zero", int'(pin_out[1]), 1);
    tick(1); chk("R7 restart count1", int'(pin_out[1]), 1);
    tick(1); chk("R7 restart count2", int'(pin_out[1]), 0);
    // R5 other channels' ticks do not start a channel
    wr(0, 0); tick(3); wr(10, 1); wr(11, 2); wr(0, 8);
    tick(0); tick(1); tick(2);
    chk("R5 foreign ticks ignored", int'(pin_out[3]), 0);
    tick(3); chk("R5 own tick starts", int'(pin_out[3]), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule